// File: doc/BRIEF.md
# Grouped Digital I/O Port with Edge Interrupt Controller

This block drives an eight-line general-purpose port and merges its edge events with other interrupt sources into one interrupt request. The eight lines are split into a low group (lines 0 to 3) and a high group (lines 4 to 7). One control bit per group makes that group an output or an input. Each pad is modelled as three vectors: output enable, output value and input value.

Every line is watched for a rising or a falling edge. The low group has one edge-select bit per line and the high group shares a single one. Edges are taken from the value actually on the pin. For an output line that value is the written value, so a software write that makes the selected transition raises an event.

Edge events, pulses from a timer, a DAC upload and an ADC conversion, and an auxiliary status pulse all set sticky bits in a 16-bit status word. Four counter-summary levels are copied into the status word without being latched. The request line is the OR of status ANDed with a 16-bit enable word, with the auxiliary bit left out. Status bits are cleared by writing ones. A handler can therefore mask everything, clear what it served, and restore the enables; any event that arrived meanwhile re-asserts the request at once.

Top module: `dio_irq_ctrl`

## Requirements
- R1: After reset the output enables, output values, status word, enable word, read-back and request line are all zero.
- R2: Control bit 10 drives the output enables of lines 0..3 and control bit 11 those of lines 4..7 (1 = output, 0 = input). These enables change only on a control write.
- R3: A data write updates the output value of output-configured lines only; output values of input lines keep their previous value.
- R4: Read-back returns, for input lines, the pad input after two synchroniser stages (visible two clocks after the pad changes) and, for output lines, the last written value (visible one clock after the write).
- R5: With edge select 0 (rising), a 0-to-1 change on an input pad sets status bit 8+n for line n on the third clock edge after the change.
- R6: Edge select for lines 0..3 comes from control bits 12..15 (bit 12+n for line n). Edge select for lines 4..7 comes from control bit 8. A value of 1 selects falling. The opposite edge sets nothing.
- R7: On an output line, a data write that makes the selected transition sets that line's status bit on the fourth clock edge after the write.
- R8: A one-cycle pulse on the timer, DAC or ADC input sets status bit 0, 1 or 2 respectively on the next clock edge.
- R9: Writing the clear word clears each sticky status bit written as 1 and leaves bits written as 0 unchanged. An event arriving in the same cycle as the clear of its bit wins, and the bit stays set.
- R10: Status bits 6, 5, 4, 3 follow counter-summary levels 0, 1, 2, 3 one clock later, and the clear word has no effect on them.
- R11: Status bit 7 is set by the auxiliary pulse and never asserts the request line, whatever the enables.
- R12: The request line is high whenever some status bit other than bit 7 is set together with its enable bit. Writing an all-zero enable word drops it in the next cycle, and restoring the enables raises it again in the next cycle if a matching status bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word (direction and edge-select bits) |
| dout_wr | input | 1 | Output data write strobe |
| dout_wdata | input | 8 | Output data value |
| rd_data | output | 8 | Port read-back |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| tmr_evt | input | 1 | Interval timer expiry pulse |
| dac_evt | input | 1 | DAC upload-done pulse |
| adc_evt | input | 1 | ADC conversion-done pulse |
| aux_evt | input | 1 | Status-only event pulse |
| cnt_lvl | input | 4 | Counter interrupt summary levels, counter 0 in bit 0 |
| ien_wr | input | 1 | Enable word write strobe |
| ien_wdata | input | 16 | Enable word value |
| clr_wr | input | 1 | Status clear strobe |
| clr_wdata | input | 16 | Write-one-to-clear mask |
| stat_o | output | 16 | Status word |
| ien_o | output | 16 | Enable word |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong sticky bit appears on `stat_o` on the clock edge after the faulty update. Because the request line is decoded combinationally from status and enables, a missed or spurious set shows on `irq_o` in that same cycle when the source is enabled. A fault in direction or output state shows on `pad_oe`, `pad_out` or `rd_data` one clock after the write that exposed it. An edge detector watching the wrong polarity, or the wrong stage of the synchroniser, moves the status update off its fixed edge-to-status latency of three clocks for a pad and four for a written output. The edge checks therefore sample both one cycle before the expected edge and on it.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;

  localparam int STAT_W     = 16;
  // status bit positions
  localparam int ST_TMR     = 0;
  localparam int ST_DAC     = 1;
  localparam int ST_ADC     = 2;
  localparam int ST_CNT_LO  = 3;
  localparam int N_CNT      = 4;
  localparam int ST_AUX     = 7;
  localparam int ST_DIO_LO  = 8;
  // control word field positions
  localparam int CF_HI_EDGE = 8;
  localparam int CF_DIR_LO  = 10;
  localparam int CF_EDGE_LO = 12;

  // status bits that may raise the request line
  localparam logic [STAT_W-1:0] IRQ_MASK = ~(STAT_W'(1) << ST_AUX);

  // one bit of edge detection: falling=1 looks for 1->0, else 0->1
  function automatic logic edge_hit(input logic now_v, input logic prev_v,
                                    input logic falling);
    return falling ? (prev_v & ~now_v) : (now_v & ~prev_v);
  endfunction

  // request reduction over status, enables and the drive mask
  function automatic logic irq_any(input logic [STAT_W-1:0] st,
                                   input logic [STAT_W-1:0] en);
    return |(st & en & IRQ_MASK);
  endfunction

  // sticky status update: events beat clears
  function automatic logic [STAT_W-1:0] sticky_next(input logic [STAT_W-1:0] cur,
                                                    input logic [STAT_W-1:0] clr,
                                                    input logic [STAT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dio_port.sv
module dio_port
  import dio_irq_pkg::*;
#(
  parameter int GRP_W  = 4,
  parameter int N_GRP  = 2,
  parameter int SYNC_N = 2,
  localparam int DW    = GRP_W * N_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [STAT_W-1:0] cfg_wdata,
  input  logic              dout_wr,
  input  logic [DW-1:0]     dout_wdata,
  input  logic [DW-1:0]     pad_in,
  output logic [DW-1:0]     pad_out,
  output logic [DW-1:0]     pad_oe,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     edge_ev
);

  logic [N_GRP-1:0] dir_q;
  logic [DW-1:0]    sel_q;
  logic [DW-1:0]    sel_d;
  logic [DW-1:0]    oe_w;
  logic [DW-1:0]    out_q;
  logic [DW-1:0]    pin_val;
  logic [DW-1:0]    sync_q;
  logic [DW-1:0]    prev_q;

  // per-line edge select: first group per bit, later groups share one bit
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      if (g == 0) begin : g_own
        assign sel_d[g*GRP_W+i] = cfg_wdata[CF_EDGE_LO+i];
      end else begin : g_shared
        assign sel_d[g*GRP_W+i] = cfg_wdata[CF_HI_EDGE];
      end
      assign oe_w[g*GRP_W+i] = dir_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      sel_q <= '0;
    end else if (cfg_wr) begin
      for (int g = 0; g < N_GRP; g++) dir_q[g] <= cfg_wdata[CF_DIR_LO+g];
      sel_q <= sel_d;
    end
  end

  // output register: only output-configured lines take the write
  always_ff @(posedge clk) begin
    if (!rst_n)       out_q <= '0;
    else if (dout_wr) out_q <= (dout_wdata & oe_w) | (out_q & ~oe_w);
  end

  // value seen on the pin, whichever side drives it
  assign pin_val = (oe_w & out_q) | (~oe_w & pad_in);

  dio_sync #(.W(DW), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_val),
    .q    (sync_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q;
  end

  always_comb begin
    for (int i = 0; i < DW; i++) edge_ev[i] = edge_hit(sync_q[i], prev_q[i], sel_q[i]);
  end

  assign pad_oe  = oe_w;
  assign pad_out = out_q;
  assign rd_data = (oe_w & out_q) | (~oe_w & sync_q);

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(pad_oe));

  // R3
  in_line_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_wr |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

  // R3
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_wr |=> $stable(pad_out));

endmodule

// File: rtl/irq_status.sv
module irq_status
  import dio_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     dio_ev,
  input  logic              tmr_evt,
  input  logic              dac_evt,
  input  logic              adc_evt,
  input  logic              aux_evt,
  input  logic [N_CNT-1:0]  cnt_lvl,
  input  logic              ien_wr,
  input  logic [STAT_W-1:0] ien_wdata,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] ien_q,
  output logic              irq
);

  localparam logic [STAT_W-1:0] CNT_MASK = STAT_W'(((1 << N_CNT) - 1) << ST_CNT_LO);
  localparam logic [STAT_W-1:0] STICKY   = ~CNT_MASK;

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] cnt_vec;
  logic [STAT_W-1:0] stat_d;

  // counter k lands on bit ST_CNT_LO + N_CNT-1-k
  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    assign cnt_vec[ST_CNT_LO+N_CNT-1-k] = cnt_lvl[k];
  end
  for (genvar b = 0; b < STAT_W; b++) begin : g_fill
    if (b < ST_CNT_LO || b >= ST_CNT_LO + N_CNT) begin : g_z
      assign cnt_vec[b] = 1'b0;
    end
  end

  always_comb begin
    set_vec = '0;
    set_vec[ST_TMR] = tmr_evt;
    set_vec[ST_DAC] = dac_evt;
    set_vec[ST_ADC] = adc_evt;
    set_vec[ST_AUX] = aux_evt;
    set_vec[ST_DIO_LO +: DW] = dio_ev;
  end

  assign clr_vec = clr_wr ? clr_wdata : '0;
  assign stat_d  = (sticky_next(stat_q, clr_vec, set_vec) & STICKY) | cnt_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ien_wr) ien_q <= ien_wdata;
    end
  end

  assign irq = irq_any(stat_q, ien_q);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_vec)) & STICKY & ~stat_q) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R11
  aux_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ien_q) == (STAT_W'(1) << ST_AUX)) |-> !irq);

  // R12
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && ien_wdata == '0) |=> !irq);

endmodule

// File: rtl/dio_irq_ctrl.sv
module dio_irq_ctrl
  import dio_irq_pkg::*;
#(
  parameter int GRP_W  = 4,
  parameter int N_GRP  = 2,
  parameter int SYNC_N = 2,
  localparam int DW    = GRP_W * N_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [STAT_W-1:0] cfg_wdata,
  input  logic              dout_wr,
  input  logic [DW-1:0]     dout_wdata,
  output logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     pad_in,
  output logic [DW-1:0]     pad_out,
  output logic [DW-1:0]     pad_oe,
  input  logic              tmr_evt,
  input  logic              dac_evt,
  input  logic              adc_evt,
  input  logic              aux_evt,
  input  logic [N_CNT-1:0]  cnt_lvl,
  input  logic              ien_wr,
  input  logic [STAT_W-1:0] ien_wdata,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_wdata,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] ien_o,
  output logic              irq_o
);

  // edge events between the port and the status unit
  logic [DW-1:0] dio_ev;

  dio_port #(.GRP_W(GRP_W), .N_GRP(N_GRP), .SYNC_N(SYNC_N)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .dout_wr   (dout_wr),
    .dout_wdata(dout_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .rd_data   (rd_data),
    .edge_ev   (dio_ev)
  );

  irq_status #(.DW(DW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .dio_ev   (dio_ev),
    .tmr_evt  (tmr_evt),
    .dac_evt  (dac_evt),
    .adc_evt  (adc_evt),
    .aux_evt  (aux_evt),
    .cnt_lvl  (cnt_lvl),
    .ien_wr   (ien_wr),
    .ien_wdata(ien_wdata),
    .clr_wr   (clr_wr),
    .clr_wdata(clr_wdata),
    .stat_q   (stat_o),
    .ien_q    (ien_o),
    .irq      (irq_o)
  );

  // R5
  edge_to_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_ev != '0) |=> ((stat_o[ST_DIO_LO +: DW] & $past(dio_ev)) == $past(dio_ev)));

endmodule

// File: tb/dio_irq_ctrl_test.sv
module dio_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        dout_wr = 1'b0;
  logic [7:0]  dout_wdata = '0;
  logic [7:0]  rd_data;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;
  logic        tmr_evt = 1'b0, dac_evt = 1'b0, adc_evt = 1'b0, aux_evt = 1'b0;
  logic [3:0]  cnt_lvl = '0;
  logic        ien_wr = 1'b0;
  logic [15:0] ien_wdata = '0;
  logic        clr_wr = 1'b0;
  logic [15:0] clr_wdata = '0;
  logic [15:0] stat_o;
  logic [15:0] ien_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .dout_wr(dout_wr), .dout_wdata(dout_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tmr_evt(tmr_evt), .dac_evt(dac_evt), .adc_evt(adc_evt), .aux_evt(aux_evt),
    .cnt_lvl(cnt_lvl),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .stat_o(stat_o), .ien_o(ien_o), .irq_o(irq_o)
  );

  // bench-side restatement of the request rule: bit 7 never counts
  function automatic logic exp_irq(input logic [15:0] st, input logic [15:0] en);
    logic [15:0] hit;
    hit = st & en;
    hit[7] = 1'b0;
    return hit != 16'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; tick(1); cfg_wr = 1'b0;
  endtask

  task automatic wr_dout(input logic [7:0] v);
    dout_wr = 1'b1; dout_wdata = v; tick(1); dout_wr = 1'b0;
  endtask

  task automatic wr_ien(input logic [15:0] v);
    ien_wr = 1'b1; ien_wdata = v; tick(1); ien_wr = 1'b0;
  endtask

  task automatic wr_clr(input logic [15:0] v);
    clr_wr = 1'b1; clr_wdata = v; tick(1); clr_wr = 1'b0;
  endtask

  task automatic settle_clear();
    tick(4); wr_clr(16'hFFFF); tick(1);
  endtask

  task automatic t_reset();
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 stat", stat_o, 16'h0000);
    chk("R1 ien", ien_o, 16'h0000);
    chk("R1 irq", irq_o, 1'b0);
  endtask

  task automatic t_dir();
    wr_cfg(16'h0400); chk("R2 low group out", pad_oe, 8'h0F);
    wr_cfg(16'h0800); chk("R2 high group out", pad_oe, 8'hF0);
    wr_cfg(16'h0C00); chk("R2 both out", pad_oe, 8'hFF);
    wr_cfg(16'h0000); chk("R2 both in", pad_oe, 8'h00);
  endtask

  task automatic t_data();
    wr_cfg(16'h0400);
    wr_dout(8'hA5);
    chk("R3 only output lines", pad_out, 8'h05);
    chk("R4 output readback", rd_data, 8'h05);
    tick(2);
    chk("R7 not yet", {24'h0, stat_o[15:8]}, 32'h00);
    tick(1);
    chk("R7 write edge", {24'h0, stat_o[15:8]}, 32'h05);
    pad_in = 8'h3A;
    tick(1);
    chk("R4 one stage only", rd_data, 8'h05);
    tick(1);
    chk("R4 input live, output held", rd_data, 8'h35);
    wr_dout(8'h00);
    pad_in = 8'h00;
    settle_clear();
    wr_cfg(16'h0000);
    settle_clear();
    chk("R9 cleared", stat_o, 16'h0000);
  endtask

  task automatic t_rise();
    pad_in = 8'h81;
    tick(2);
    chk("R5 two edges not yet", {24'h0, stat_o[15:8]}, 32'h00);
    tick(1);
    chk("R5 third edge set", {24'h0, stat_o[15:8]}, 32'h81);
    wr_clr(16'hFF00);
    pad_in = 8'h00;
    tick(4);
    chk("R6 falling ignored under rising", {24'h0, stat_o[15:8]}, 32'h00);
  endtask

  task automatic t_fall();
    wr_cfg(16'hA100);
    pad_in = 8'hFF;
    tick(4);
    chk("R6 rising on rising-select lines", {24'h0, stat_o[15:8]}, 32'h05);
    wr_clr(16'hFF00);
    pad_in = 8'h00;
    tick(4);
    chk("R6 falling on falling-select lines", {24'h0, stat_o[15:8]}, 32'hFA);
    wr_cfg(16'h0000);
    settle_clear();
  endtask

  task automatic t_out_edge();
    wr_cfg(16'h0800);
    wr_dout(8'h3F);
    chk("R3 high group only", pad_out, 8'h30);
    tick(2);
    chk("R7 not yet", {24'h0, stat_o[15:8]}, 32'h00);
    tick(1);
    chk("R7 rising write", {24'h0, stat_o[15:8]}, 32'h30);
    wr_clr(16'hFF00);
    wr_cfg(16'h0900);
    wr_dout(8'h00);
    tick(3);
    chk("R7 falling write", {24'h0, stat_o[15:8]}, 32'h30);
    wr_cfg(16'h0000);
    settle_clear();
  endtask

  task automatic t_src();
    tmr_evt = 1'b1; dac_evt = 1'b1; adc_evt = 1'b1;
    tick(1);
    tmr_evt = 1'b0; dac_evt = 1'b0; adc_evt = 1'b0;
    chk("R8 sources set", stat_o, 16'h0007);
    wr_clr(16'h0007);
    dac_evt = 1'b1; tick(1); dac_evt = 1'b0;
    chk("R8 dac alone", stat_o, 16'h0002);
    wr_clr(16'h0002);
    aux_evt = 1'b1; tick(1); aux_evt = 1'b0;
    chk("R11 aux sets bit 7", stat_o, 16'h0080);
    wr_ien(16'hFFFF);
    chk("R11 aux never requests", irq_o, 1'b0);
    wr_ien(16'h0000);
  endtask

  task automatic t_w1c();
    tmr_evt = 1'b1; adc_evt = 1'b1; tick(1); tmr_evt = 1'b0; adc_evt = 1'b0;
    wr_clr(16'h0000);
    chk("R9 zero write keeps", stat_o, 16'h0085);
    wr_clr(16'h0001);
    chk("R9 one clears", stat_o, 16'h0084);
    clr_wr = 1'b1; clr_wdata = 16'h0001; tmr_evt = 1'b1;
    tick(1);
    clr_wr = 1'b0; tmr_evt = 1'b0;
    chk("R9 event beats clear", stat_o, 16'h0085);
    wr_clr(16'hFFFF);
    chk("R9 all cleared", stat_o, 16'h0000);
  endtask

  task automatic t_cnt();
    cnt_lvl = 4'b0001;
    tick(1);
    chk("R10 counter 0 on bit 6", stat_o & 16'h0078, 16'h0040);
    wr_clr(16'h0078);
    chk("R10 clear has no effect", stat_o & 16'h0078, 16'h0040);
    cnt_lvl = 4'b1000;
    tick(1);
    chk("R10 counter 3 on bit 3", stat_o & 16'h0078, 16'h0008);
    wr_ien(16'h0008);
    chk("R12 counter level requests", irq_o, exp_irq(16'h0008, 16'h0008));
    cnt_lvl = 4'b0000;
    tick(1);
    chk("R10 level gone", irq_o, 1'b0);
    wr_ien(16'h0000);
  endtask

  task automatic t_irq();
    wr_ien(16'h0100);
    chk("R12 enable readback", ien_o, 16'h0100);
    pad_in = 8'h01;
    tick(2);
    chk("R12 no request before status", irq_o, 1'b0);
    tick(1);
    chk("R12 request with status", irq_o, 1'b1);
    wr_ien(16'h0000);
    chk("R12 mask drops request", irq_o, 1'b0);
    tmr_evt = 1'b1; tick(1); tmr_evt = 1'b0;
    wr_clr(16'h0100);
    chk("R12 still low while masked", irq_o, 1'b0);
    wr_ien(16'h0101);
    chk("R12 restore re-raises", irq_o, exp_irq(stat_o, 16'h0101));
    chk("R12 pending timer bit", stat_o, 16'h0001);
    wr_clr(16'h0001);
    chk("R12 clear drops request", irq_o, 1'b0);
    pad_in = 8'h00;
    wr_ien(16'h0000);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_dir();
    t_data();
    t_rise();
    t_fall();
    t_out_edge();
    t_src();
    t_w1c();
    t_cnt();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule